// File: doc/BRIEF.md
# Frame Waiting Time Supervisor

This block guards the listening window of a proximity-card reader. Once the reader has switched to receive mode and pulses `rx_start`, the supervisor counts enabled sample-clock ticks from zero. It reports one of two results: the demodulator signalled a complete card frame, or the count went past the permitted waiting time. The result and the elapsed count stay on the outputs until the next window opens.

The permitted waiting time is not fixed. Out of reset it is 60000 ticks. When the reader loads the parameter byte that carries the card's frame-waiting integer, the upper nibble of that byte is taken as an exponent. The new limit is a base of 302 ticks shifted left by that exponent. A range check on the exponent is kept, so an exponent at or above the configured bound leaves the old limit in place.

There is no data stream here. Every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. Strobes are taken on the clock edge where they are high. `tick_en` qualifies counting only, and not the strobes.

Top module: `fwt_supervisor`

## Requirements
- R1: After reset `timed_out` and `rx_finished` are 0, `elapsed` is 0, and the waiting limit is 60000 ticks.
- R2: A cycle with `atr_load` high takes the exponent from `atr_byte[7:4]` and sets the limit to 302 << exponent. `atr_byte[3:0]` has no effect.
- R3: A load whose exponent is at or above `EXP_LIMIT` (default 16) leaves the limit unchanged.
- R4: A cycle with `rx_start` high clears `elapsed`, `timed_out` and `rx_finished` and opens a window, even if a window is already open. While the window is open, `elapsed` grows by one on each cycle with `tick_en` high and holds on the other cycles.
- R5: On the tick that makes `elapsed` strictly greater than the limit, both `timed_out` and `rx_finished` go to 1 and the window closes.
- R6: `frame_done` in an open window sets `rx_finished` to 1 with `timed_out` left at 0 and closes the window. The tick of that same cycle is still counted.
- R7: If `frame_done` arrives on the same tick as the limit crossing, the result is a success: `rx_finished` is 1 and `timed_out` is 0.
- R8: After a window closes, `rx_finished`, `timed_out` and `elapsed` hold their values until the next `rx_start`. `frame_done` outside an open window has no effect.
- R9: `elapsed` saturates at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Sample-clock tick enable |
| atr_load | input | 1 | Load strobe for the parameter byte |
| atr_byte | input | 8 | Parameter byte; upper nibble is the exponent |
| rx_start | input | 1 | Pulse: receive mode entered, window opens |
| frame_done | input | 1 | Pulse: demodulator reports a complete frame |
| timed_out | output | 1 | Window closed by timeout |
| rx_finished | output | 1 | Window closed (frame or timeout) |
| elapsed | output | CNT_W | Ticks counted in the current or last window |

## Verification
On every cycle the assertions check the following. An open window's count never goes backwards. `rx_start` clears the counter. A saturated count stays saturated. Closed results hold. A frame seen in an open window always ends as a success. A rising `timed_out` always comes with a count above the limit. An out-of-range exponent never moves the limit. Some behaviour depends on the exact tick count and only the bench scenarios show it. These are the 60000-tick reset limit, the shifted limits for several exponents, the strict crossing point, counting with gaps in `tick_en`, restart in mid-window, and saturation in a narrow configuration. In that configuration the counter can never pass the limit.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
  typedef enum logic [1:0] {
    FWT_IDLE    = 2'd0,
    FWT_WAIT    = 2'd1,
    FWT_DONE_OK = 2'd2,
    FWT_DONE_TO = 2'd3
  } fwt_state_e;
endpackage

// File: rtl/fwt_limit_reg.sv
module fwt_limit_reg #(
  parameter int CNT_W       = 32,
  parameter int EXP_W       = 4,
  parameter int EXP_LIMIT   = 16,
  parameter int BASE        = 302,
  parameter int RESET_LIMIT = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EXP_W-1:0] exp_in,
  output logic [CNT_W-1:0] limit
);
  localparam logic [CNT_W-1:0] BASE_V  = CNT_W'(BASE);
  localparam logic [CNT_W-1:0] RESET_V = CNT_W'(RESET_LIMIT);
  localparam logic [EXP_W:0]   BOUND_V = (EXP_W+1)'(EXP_LIMIT);

  logic exp_ok;
  assign exp_ok = {1'b0, exp_in} < BOUND_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              limit <= RESET_V;
    else if (load && exp_ok) limit <= BASE_V << exp_in;
  end

  AST_BAD_EXP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !({1'b0, exp_in} < BOUND_V)) |=> $stable(limit)); // R3
endmodule

// File: rtl/fwt_elapsed_ctr.sv
module fwt_elapsed_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] MAX_V = '1;

  assign cnt_nxt = (cnt == MAX_V) ? MAX_V : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt_nxt;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R4
  AST_NO_BACKWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt))); // R4
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && cnt == MAX_V) |=> (cnt == MAX_V)); // R9
endmodule

// File: rtl/fwt_verdict.sv
module fwt_verdict
  import fwt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             frame_done,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] limit,
  output logic             waiting,
  output logic             timed_out,
  output logic             finished
);
  fwt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rx_start)
      state_d = FWT_WAIT;
    else if (state_q == FWT_WAIT) begin
      if (frame_done)                       state_d = FWT_DONE_OK;
      else if (tick_en && (cnt_nxt > limit)) state_d = FWT_DONE_TO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FWT_IDLE;
    else        state_q <= state_d;
  end

  assign waiting   = (state_q == FWT_WAIT);
  assign timed_out = (state_q == FWT_DONE_TO);
  assign finished  = (state_q == FWT_DONE_OK) || (state_q == FWT_DONE_TO);

  AST_FRAME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && frame_done && !rx_start) |=> (finished && !timed_out)); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !rx_start) |=> ($stable(finished) && $stable(timed_out))); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> (!finished && !timed_out)); // R4
endmodule

// File: rtl/fwt_supervisor.sv
module fwt_supervisor #(
  parameter int CNT_W       = 32,
  parameter int EXP_W       = 4,
  parameter int EXP_LIMIT   = 16,
  parameter int BASE        = 302,
  parameter int RESET_LIMIT = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             atr_load,
  input  logic [7:0]       atr_byte,
  input  logic             rx_start,
  input  logic             frame_done,
  output logic             timed_out,
  output logic             rx_finished,
  output logic [CNT_W-1:0] elapsed
);
  localparam int EXP_LSB = 8 - EXP_W;

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_nxt;
  logic             waiting;

  fwt_limit_reg #(
    .CNT_W(CNT_W), .EXP_W(EXP_W), .EXP_LIMIT(EXP_LIMIT),
    .BASE(BASE), .RESET_LIMIT(RESET_LIMIT)
  ) u_limit (
    .clk(clk), .rst_n(rst_n), .load(atr_load),
    .exp_in(atr_byte[7:EXP_LSB]), .limit(limit)
  );

  fwt_elapsed_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(rx_start),
    .en(waiting && tick_en), .cnt(elapsed), .cnt_nxt(cnt_nxt)
  );

  fwt_verdict #(.CNT_W(CNT_W)) u_verdict (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start),
    .frame_done(frame_done), .tick_en(tick_en), .cnt_nxt(cnt_nxt),
    .limit(limit), .waiting(waiting), .timed_out(timed_out),
    .finished(rx_finished)
  );

  AST_TIMEOUT_EXCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> (elapsed > limit)); // R5
endmodule

// File: tb/sim_fwt_supervisor.sv
module sim_fwt_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       tk [2];
  logic       ld [2];
  logic       rs [2];
  logic       fd [2];
  logic [7:0] pb [2];

  logic        to0, fin0, to1, fin1;
  logic [31:0] el0;
  logic [9:0]  el1;

  fwt_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tk[0]), .atr_load(ld[0]),
    .atr_byte(pb[0]), .rx_start(rs[0]), .frame_done(fd[0]),
    .timed_out(to0), .rx_finished(fin0), .elapsed(el0)
  );

  fwt_supervisor #(.CNT_W(10), .EXP_LIMIT(4), .RESET_LIMIT(1023)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_en(tk[1]), .atr_load(ld[1]),
    .atr_byte(pb[1]), .rx_start(rs[1]), .frame_done(fd[1]),
    .timed_out(to1), .rx_finished(fin1), .elapsed(el1)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference, one slot per instance
  longint m_lim [2], m_el [2];
  bit     m_act [2], m_fin [2], m_to [2];
  longint p_max [2] = '{64'd4294967295, 64'd1023};
  longint p_rst [2] = '{64'd60000, 64'd1023};
  int     p_bnd [2] = '{16, 4};

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_lim[i] = p_rst[i]; m_el[i] = 0; m_act[i] = 0; m_fin[i] = 0; m_to[i] = 0;
      end else begin
        longint nl, ne;
        int e;
        nl = m_lim[i];
        e = int'(pb[i] >> 4);
        if (ld[i] && e < p_bnd[i]) nl = (longint'(302) << e) & p_max[i];
        if (rs[i]) begin
          m_el[i] = 0; m_act[i] = 1; m_fin[i] = 0; m_to[i] = 0;
        end else if (m_act[i]) begin
          ne = m_el[i];
          if (tk[i]) ne = (m_el[i] + 1 > p_max[i]) ? p_max[i] : m_el[i] + 1;
          if (fd[i]) begin
            m_fin[i] = 1; m_to[i] = 0; m_act[i] = 0;
          end else if (tk[i] && ne > m_lim[i]) begin
            m_fin[i] = 1; m_to[i] = 1; m_act[i] = 0;
          end
          m_el[i] = ne;
        end
        m_lim[i] = nl;
      end
    end
  end

  function automatic void cmp(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("u0 state", {fin0, to0, el0}, {m_fin[0], m_to[0], 32'(m_el[0])});
      cmp("u1 state", {fin1, to1, el1}, {m_fin[1], m_to[1], 10'(m_el[1])});
    end
  end

  task automatic chk(int i, bit f, bit t, longint e, string req);
    string sv;
    sv = cur_req; cur_req = req;
    if (i == 0) cmp("explicit", {fin0, to0, el0}, {f, t, 32'(e)});
    else        cmp("explicit", {fin1, to1, el1}, {f, t, 10'(e)});
    cur_req = sv;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(int i);
    rs[i] = 1'b1; @(negedge clk); rs[i] = 1'b0;
  endtask

  task automatic load(int i, logic [7:0] b);
    pb[i] = b; ld[i] = 1'b1; @(negedge clk); ld[i] = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      tk[i] = 1'b1; ld[i] = 1'b0; rs[i] = 1'b0; fd[i] = 1'b0; pb[i] = 8'h00;
    end
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    cur_req = "R1";
    chk(0, 0, 0, 0, "R1");
    chk(1, 0, 0, 0, "R1");

    // default limit 60000: strict crossing at tick 60001
    cur_req = "R5";
    start(0);
    wait_n(60000);
    chk(0, 0, 0, 60000, "R1");
    wait_n(1);
    chk(0, 1, 1, 60001, "R5");
    cur_req = "R8";
    wait_n(5);
    chk(0, 1, 1, 60001, "R8");

    // exponent 2 -> 1208
    cur_req = "R2";
    load(0, 8'h2A);
    start(0);
    wait_n(1208);
    chk(0, 0, 0, 1208, "R2");
    wait_n(1);
    chk(0, 1, 1, 1209, "R2");
    // exponent 0, low nibble ignored -> 302
    load(0, 8'h0F);
    start(0);
    wait_n(302);
    chk(0, 0, 0, 302, "R2");
    wait_n(1);
    chk(0, 1, 1, 303, "R2");

    // gaps in tick enable
    cur_req = "R4";
    start(0);
    for (int k = 0; k < 20; k++) begin
      tk[0] = k[0];
      @(negedge clk);
    end
    tk[0] = 1'b1;
    chk(0, 0, 0, 10, "R4");
    // restart mid-window
    wait_n(30);
    start(0);
    chk(0, 0, 0, 0, "R4");

    // frame in window
    cur_req = "R6";
    wait_n(49);
    fd[0] = 1'b1; @(negedge clk); fd[0] = 1'b0;
    chk(0, 1, 0, 50, "R6");
    cur_req = "R8";
    wait_n(10);
    fd[0] = 1'b1; @(negedge clk); fd[0] = 1'b0;
    wait_n(3);
    chk(0, 1, 0, 50, "R8");

    // frame on the crossing tick (limit 302)
    cur_req = "R7";
    start(0);
    wait_n(302);
    fd[0] = 1'b1; @(negedge clk); fd[0] = 1'b0;
    chk(0, 1, 0, 303, "R7");

    // saturation on the narrow instance (limit 1023 = counter max)
    cur_req = "R9";
    start(1);
    wait_n(1100);
    chk(1, 0, 0, 1023, "R9");

    // out-of-range exponent on the narrow instance (bound 4)
    cur_req = "R3";
    tk[1] = 1'b0;
    start(1);
    load(1, 8'h10);
    load(1, 8'h50);
    load(1, 8'hF3);
    tk[1] = 1'b1;
    start(1);
    wait_n(604);
    chk(1, 0, 0, 604, "R3");
    wait_n(1);
    chk(1, 1, 1, 605, "R3");

    wait_n(4);
    finish_run();
  end
endmodule